// File: doc/BRIEF.md
# Protection Unit Configuration Register Bank

This block holds the software-visible settings of a memory protection unit whose region count is a parameter. A small synchronous register port gives access to it: a word address, a write strobe, a read strobe, write data and registered read data. Five words are decoded. The first is a read-only identification word that carries the region count. The second is a global control word. The third is a region selector. The last two are a base word and a limit word, and both act on the region that the selector names.

Every stored region field and the global mode flags are driven out as flat buses to the address-lookup logic beside this bank. Some programming cases are undefined, and the bank turns each of them into a fixed result rather than rejecting it. A selector value past the last region wraps by masking. The reserved shareability code is stored as non-shareable. When protection is switched off but the high-priority-handler flag is set, accesses from high-priority handlers fall back to the default map along with all other accesses.

Top module: `pu_cfg_bank`

## Requirements
- R1: After reset, every region enable is 0, the control word is 0 (so `prot_en_o`, `hpri_check_o` and `bg_map_o` are 0), the selector reads 0 and `rdata` is 0.
- R2: When `rd_en` is high at a clock edge, `rdata` presents the addressed word from that edge onward. While `rd_en` is low, `rdata` holds its value, including across writes.
- R3: Word address 0 is read-only. It returns NUM_REGIONS in bits [15:8] and zeros in every other bit, and writes to it have no effect.
- R4: A write to word address 2 (selector) stores the write data AND (NUM_REGIONS-1). With 8 regions, writing 9 selects region 1 and writing 15 selects region 7. A read returns the stored value.
- R5: Word address 3 (base) and word address 4 (limit) read and write the region named by the stored selector. Base layout: [31:5] base address, [4:3] shareability, [2:1] access permission, [0] execute-never. Limit layout: [31:5] limit address, [4] reads 0, [3:1] attribute index, [0] region enable.
- R6: A base write with shareability code 2'b01 stores 2'b00, and 2'b00 is what both the read-back and the `rgn_sh_o` output show. Every other code is kept as written.
- R7: Word address 1 (control) holds bit 0 protection enable, bit 1 high-priority-handler check enable and bit 2 background-map enable. It reads back bits [2:0] as written, with the upper bits 0.
- R8: `prot_en_o` equals the protection enable bit. `hpri_check_o` is 1 only when the protection enable bit and the handler bit are both 1. With protection enable 0 and handler bit 1, both outputs are 0, so every access uses the default map.
- R9: The per-region outputs show each region's stored fields at slice i of each bus. A base or limit write changes only the selected region.
- R10: Word addresses 5 to 7 read as 0, and writes to them change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; loads rdata at the edge |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| prot_en_o | output | 1 | Region checking active for normal accesses |
| hpri_check_o | output | 1 | Region checking active for high-priority handlers |
| bg_map_o | output | 1 | Background default map enabled for privileged accesses |
| rgn_base_o | output | 27*NUM_REGIONS | Base address [31:5] per region |
| rgn_limit_o | output | 27*NUM_REGIONS | Limit address [31:5] per region |
| rgn_sh_o | output | 2*NUM_REGIONS | Shareability per region, reserved code coerced |
| rgn_ap_o | output | 2*NUM_REGIONS | Access permission per region |
| rgn_xn_o | output | NUM_REGIONS | Execute-never per region |
| rgn_attr_o | output | 3*NUM_REGIONS | Attribute index per region |
| rgn_en_o | output | NUM_REGIONS | Region enable per region |

## Verification
The bench writes selector values of 9, 10 and 15 with eight regions. A design that rejected these values or kept all their bits would read back the wrong selector and would write the wrong region, which the region outputs would show. It writes shareability 2'b01 and then 2'b10. A design that passed the reserved code through would show 2'b01 on the output and in the read-back, and one that coerced too much would change the legal code. It programs protection off with the handler flag on. A design that decoded the handler flag on its own would leave `hpri_check_o` high while protection is off. It also tests writes to the read-only and unmapped words, and checks that `rdata` holds while no read is issued.

// File: rtl/pu_cfg_pkg.sv
package pu_cfg_pkg;

    localparam int ADDR_W = 3;
    localparam int FLD_W  = 27;

    localparam logic [ADDR_W-1:0] WA_TYPE  = 3'd0;
    localparam logic [ADDR_W-1:0] WA_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] WA_SEL   = 3'd2;
    localparam logic [ADDR_W-1:0] WA_BASE  = 3'd3;
    localparam logic [ADDR_W-1:0] WA_LIMIT = 3'd4;

    localparam logic [1:0] SH_NONE = 2'b00;
    localparam logic [1:0] SH_RSVD = 2'b01;

    typedef struct packed {
        logic             bg;
        logic             hf;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic [FLD_W-1:0] base;
        logic [FLD_W-1:0] limit;
        logic [1:0]       sh;
        logic [1:0]       ap;
        logic             xn;
        logic [2:0]       attr;
        logic             en;
    } rgn_t;

    function automatic logic [1:0] coerce_sh(input logic [1:0] code);
        return (code == SH_RSVD) ? SH_NONE : code;
    endfunction

endpackage

// File: rtl/pu_cfg_region.sv
module pu_cfg_region
    import pu_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_base,
    input  logic        wr_limit,
    input  logic [31:0] wdata,
    output rgn_t        rgn_q
);

    rgn_t rgn_d;
    logic unused_rsvd_bit;

    assign unused_rsvd_bit = wdata[4];

    always_comb begin
        rgn_d = rgn_q;
        if (wr_base) begin
            rgn_d.base = wdata[31:5];
            rgn_d.sh   = coerce_sh(wdata[4:3]);
            rgn_d.ap   = wdata[2:1];
            rgn_d.xn   = wdata[0];
        end
        if (wr_limit) begin
            rgn_d.limit = wdata[31:5];
            rgn_d.attr  = wdata[3:1];
            rgn_d.en    = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_q <= '0;
        end else begin
            rgn_q <= rgn_d;
        end
    end

endmodule

// File: rtl/pu_cfg_ctrl.sv
module pu_cfg_ctrl
    import pu_cfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_sel,
    input  logic [3:0]       wdata_lo,
    output ctrl_t            ctrl_q,
    output logic [IDX_W-1:0] sel_q,
    output logic             prot_en,
    output logic             hpri_check,
    output logic             bg_map
);

    localparam logic [IDX_W-1:0] SEL_MASK = IDX_W'(NUM_REGIONS - 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [IDX_W-1:0] sel;
    } st_t;

    st_t  st_d, st_q;
    logic unused_sel_hi;

    assign unused_sel_hi = wdata_lo[3];

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.en = wdata_lo[0];
            st_d.ctrl.hf = wdata_lo[1];
            st_d.ctrl.bg = wdata_lo[2];
        end
        if (wr_sel) begin
            st_d.sel = wdata_lo[IDX_W-1:0] & SEL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q     = st_q.ctrl;
    assign sel_q      = st_q.sel;
    assign prot_en    = st_q.ctrl.en;
    assign hpri_check = st_q.ctrl.en & st_q.ctrl.hf;
    assign bg_map     = st_q.ctrl.bg;

endmodule

// File: rtl/pu_cfg_rdport.sv
module pu_cfg_rdport
    import pu_cfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [31:0]       sel_word,
    input  rgn_t              rgn_cur,
    output logic [31:0]       rdata
);

    localparam logic [31:0] TYPE_WORD = {16'h0, 8'(NUM_REGIONS), 8'h0};

    logic [31:0] rdata_d, rdata_q, word;

    always_comb begin
        case (addr)
            WA_TYPE:  word = TYPE_WORD;
            WA_CTRL:  word = {29'h0, ctrl.bg, ctrl.hf, ctrl.en};
            WA_SEL:   word = sel_word;
            WA_BASE:  word = {rgn_cur.base, rgn_cur.sh, rgn_cur.ap, rgn_cur.xn};
            WA_LIMIT: word = {rgn_cur.limit, 1'b0, rgn_cur.attr, rgn_cur.en};
            default:  word = '0;
        endcase
        rdata_d = rd_en ? word : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pu_cfg_bank.sv
module pu_cfg_bank
    import pu_cfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [2:0]                   addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    output logic                         prot_en_o,
    output logic                         hpri_check_o,
    output logic                         bg_map_o,
    output logic [FLD_W*NUM_REGIONS-1:0] rgn_base_o,
    output logic [FLD_W*NUM_REGIONS-1:0] rgn_limit_o,
    output logic [2*NUM_REGIONS-1:0]     rgn_sh_o,
    output logic [2*NUM_REGIONS-1:0]     rgn_ap_o,
    output logic [NUM_REGIONS-1:0]       rgn_xn_o,
    output logic [3*NUM_REGIONS-1:0]     rgn_attr_o,
    output logic [NUM_REGIONS-1:0]       rgn_en_o
);

    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    generate
        if (NUM_REGIONS < 1 || NUM_REGIONS > 16 ||
            (NUM_REGIONS & (NUM_REGIONS - 1)) != 0) begin : g_bad_param
            $error("NUM_REGIONS must be a power of two from 1 to 16");
        end
    endgenerate

    logic             wr_ctrl, wr_sel, wr_base, wr_limit;
    ctrl_t            ctrl_q;
    logic [IDX_W-1:0] sel_q;
    rgn_t             rgn_arr [NUM_REGIONS];
    rgn_t             rgn_cur;

    assign wr_ctrl  = wr_en && (addr == WA_CTRL);
    assign wr_sel   = wr_en && (addr == WA_SEL);
    assign wr_base  = wr_en && (addr == WA_BASE);
    assign wr_limit = wr_en && (addr == WA_LIMIT);

    pu_cfg_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_sel     (wr_sel),
        .wdata_lo   (wdata[3:0]),
        .ctrl_q     (ctrl_q),
        .sel_q      (sel_q),
        .prot_en    (prot_en_o),
        .hpri_check (hpri_check_o),
        .bg_map     (bg_map_o)
    );

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
            pu_cfg_region u_rgn (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_base  (wr_base  && (sel_q == IDX_W'(g))),
                .wr_limit (wr_limit && (sel_q == IDX_W'(g))),
                .wdata    (wdata),
                .rgn_q    (rgn_arr[g])
            );
            assign rgn_base_o [g*FLD_W +: FLD_W] = rgn_arr[g].base;
            assign rgn_limit_o[g*FLD_W +: FLD_W] = rgn_arr[g].limit;
            assign rgn_sh_o   [g*2 +: 2]         = rgn_arr[g].sh;
            assign rgn_ap_o   [g*2 +: 2]         = rgn_arr[g].ap;
            assign rgn_xn_o   [g]                = rgn_arr[g].xn;
            assign rgn_attr_o [g*3 +: 3]         = rgn_arr[g].attr;
            assign rgn_en_o   [g]                = rgn_arr[g].en;
        end
    endgenerate

    always_comb begin
        rgn_cur = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (sel_q == IDX_W'(i)) begin
                rgn_cur = rgn_arr[i];
            end
        end
    end

    pu_cfg_rdport #(.NUM_REGIONS(NUM_REGIONS)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .ctrl     (ctrl_q),
        .sel_word (32'(sel_q)),
        .rgn_cur  (rgn_cur),
        .rdata    (rdata)
    );

endmodule

// File: rtl/pu_cfg_chk.sv
module pu_cfg_chk #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [2:0]               addr,
    input logic [31:0]              wdata,
    input logic [31:0]              rdata,
    input logic                     prot_en_o,
    input logic                     hpri_check_o,
    input logic [2*NUM_REGIONS-1:0] rgn_sh_o,
    input logic [NUM_REGIONS-1:0]   rgn_en_o,
    input logic [IDX_W-1:0]         sel_q
);

    localparam logic [IDX_W-1:0] MASK = IDX_W'(NUM_REGIONS - 1);
    localparam logic [31:0] TYPE_WORD = {16'h0, 8'(NUM_REGIONS), 8'h0};

    // R8
    hpri_implies_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hpri_check_o |-> prot_en_o);

    // R8
    default_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && wdata[1:0] == 2'b10) |=> (!prot_en_o && !hpri_check_o));

    // R4
    sel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2) |=> (sel_q == ($past(wdata[IDX_W-1:0]) & MASK)));

    // R3
    type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0) |=> (rdata == TYPE_WORD));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > 3'd4) |=> (rdata == 32'h0));

    // R9
    en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd4) |=> $stable(rgn_en_o));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sh
            // R6
            sh_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rgn_sh_o[g*2 +: 2] != 2'b01);
        end
    endgenerate

endmodule

bind pu_cfg_bank pu_cfg_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .prot_en_o    (prot_en_o),
    .hpri_check_o (hpri_check_o),
    .rgn_sh_o     (rgn_sh_o),
    .rgn_en_o     (rgn_en_o),
    .sel_q        (sel_q)
);

// File: tb/pu_cfg_bank_bench.sv
module pu_cfg_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int FW = 27;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en;
    logic [2:0]        addr;
    logic [31:0]       wdata, rdata;
    logic              prot_en_o, hpri_check_o, bg_map_o;
    logic [FW*NR-1:0]  rgn_base_o, rgn_limit_o;
    logic [2*NR-1:0]   rgn_sh_o, rgn_ap_o;
    logic [NR-1:0]     rgn_xn_o, rgn_en_o;
    logic [3*NR-1:0]   rgn_attr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pu_cfg_bank #(.NUM_REGIONS(NR)) u_pu_cfg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .prot_en_o(prot_en_o),
        .hpri_check_o(hpri_check_o), .bg_map_o(bg_map_o),
        .rgn_base_o(rgn_base_o), .rgn_limit_o(rgn_limit_o), .rgn_sh_o(rgn_sh_o),
        .rgn_ap_o(rgn_ap_o), .rgn_xn_o(rgn_xn_o), .rgn_attr_o(rgn_attr_o),
        .rgn_en_o(rgn_en_o)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard one cycle after each read strobe
    logic rd_seen;
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(64'(rdata), 64'hDEAD, "scoreboard underflow");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(64'(rdata), 64'(e.v), e.tag);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back('{e, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(64'(rgn_en_o), 64'h0, "R1 region enables");
        chk(64'({prot_en_o, hpri_check_o, bg_map_o}), 64'h0, "R1 mode outputs");
        chk(64'(rdata), 64'h0, "R1 rdata");
        rd(3'd2, 32'h0, "R1 selector");
        rd(3'd1, 32'h0, "R1 control");

        // R3 identification word
        rd(3'd0, 32'h0000_0800, "R3 type word");
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0000_0800, "R3 type after write");

        // R4 selector masking
        wr(3'd2, 32'd9);
        rd(3'd2, 32'd1, "R4 sel 9 -> 1");
        wr(3'd2, 32'd15);
        rd(3'd2, 32'd7, "R4 sel 15 -> 7");
        wr(3'd2, 32'd3);
        rd(3'd2, 32'd3, "R4 sel 3");

        // R6 reserved shareability, region 2
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h2000_000D);
        rd(3'd3, 32'h2000_0005, "R6 base read coerced");
        chk(64'(rgn_sh_o[4 +: 2]), 64'h0, "R6 sh output coerced");
        chk(64'(rgn_ap_o[4 +: 2]), 64'h2, "R5 ap output");
        chk(64'(rgn_xn_o[2]), 64'h1, "R5 xn output");
        chk(64'(rgn_base_o[2*FW +: FW]), 64'h100_0000, "R9 base slice");
        wr(3'd3, 32'h2000_0015);
        rd(3'd3, 32'h2000_0015, "R6 legal code kept");
        chk(64'(rgn_sh_o[4 +: 2]), 64'h2, "R6 sh output kept");

        // R5 limit word and R9 per-region outputs
        wr(3'd4, 32'h2000_0FFB);
        rd(3'd4, 32'h2000_0FEB, "R5 limit read, bit 4 zero");
        chk(64'(rgn_en_o), 64'h04, "R9 enable region 2 only");
        chk(64'(rgn_attr_o[6 +: 3]), 64'h5, "R9 attr slice");
        chk(64'(rgn_limit_o[2*FW +: FW]), 64'h100_007F, "R9 limit slice");
        wr(3'd2, 32'd10);
        rd(3'd4, 32'h2000_0FEB, "R4 sel 10 reaches region 2");
        wr(3'd2, 32'd5);
        rd(3'd4, 32'h0, "R9 region 5 untouched");
        wr(3'd4, 32'h0000_0001);
        chk(64'(rgn_en_o), 64'h24, "R9 enable region 5");

        // R8 / R7 control
        wr(3'd1, 32'h2);
        chk(64'({prot_en_o, hpri_check_o}), 64'h0, "R8 off with handler flag -> default map");
        rd(3'd1, 32'h2, "R7 control readback");
        wr(3'd1, 32'h3);
        chk(64'({prot_en_o, hpri_check_o}), 64'h3, "R8 both on");
        wr(3'd1, 32'h1);
        chk(64'({prot_en_o, hpri_check_o}), 64'h2, "R8 enable only");
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h7, "R7 upper bits dropped");
        chk(64'(bg_map_o), 64'h1, "R7 background map");

        // R10 unmapped words
        wr(3'd6, 32'hDEAD_BEEF);
        rd(3'd6, 32'h0, "R10 unmapped read");
        rd(3'd1, 32'h7, "R10 control untouched");
        chk(64'(rgn_en_o), 64'h24, "R10 regions untouched");

        // R2 read data holds without a read strobe
        repeat (3) @(negedge clk);
        chk(64'(rdata), 64'h7, "R2 hold idle");
        wr(3'd1, 32'h1);
        chk(64'(rdata), 64'h7, "R2 hold across write");

        repeat (2) @(negedge clk);
        chk(64'(exp_q.size()), 64'h0, "scoreboard drained");
        finish_run();
    end

endmodule